// File: doc/BRIEF.md
# Diagnostic Buffer-Memory Access Window

This block gives a host a narrow register window into an external 16-bit-word buffer memory so that software can inspect and patch it during diagnostics. The host first programs a word address split across two registers: an upper register that holds the high address bits and a target-select bit, and a lower register that holds the low address bits. It then touches a data-port register. A write to the data port issues one memory write. A read of the data port starts a fetch and answers with retry. Once the fetched word is held, the next read returns it.

The window is open only while the surrounding controller is stopped, or suspended with fast-suspend turned off. In every other operating mode, host accesses are dropped without effect. The memory side is a valid/ready request channel followed by a one-cycle response strobe for reads. The host side is a single-cycle access strobe with a combinational retry and read-data answer in the same cycle.

Top module: `sram_diag_port`

## Requirements
- R1: The register index selects the upper-address register (0), the lower-address register (1), the data port (2) or a reserved slot (3). Upper-register writes store wdata[3:0] as the high address and wdata[15] as the target select. Upper reads return select at bit 15, the high address at bits 3:0 and zero elsewhere. The lower register stores and returns all 16 bits. The reserved slot reads 0 and ignores writes.
- R2: The memory word address is the high address concatenated above the low address, 20 bits in all, with one 16-bit word per address.
- R3: A data-port read while no fetched word is held answers retry and launches exactly one read request at the current address. The first data-port read after reset therefore always retries.
- R4: A data-port read while a fetched word is held returns that word with no retry and releases it. The following data-port read retries and fetches again.
- R5: A data-port write answers without retry and issues one memory write carrying the written word at the current address.
- R6: While a memory cycle is outstanding, every permitted host access answers retry with read data 0 and changes nothing.
- R7: Access is permitted only when stopped=1, or when suspended=1 with fast-suspend=0. Otherwise an access answers without retry, reads return 0, and no register or memory request is affected.
- R8: With the target select set to 1, data-port accesses are ignored: no memory request is issued, no retry is given, and reads return 0.
- R9: A permitted write to either address register or to the data port discards any held fetched word.
- R10: A request stays valid, with address, direction and write data unchanged, until ready is seen high. The read response is taken in the single cycle its valid strobe is high, and the response has no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_stopped | input | 1 | Controller is in the stopped state |
| ctl_suspended | input | 1 | Controller is in suspend |
| ctl_fast_susp | input | 1 | Fast-suspend enabled |
| hst_sel | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write access, 0 = read access |
| hst_reg | input | 2 | Register index |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid during the strobe cycle |
| hst_retry | output | 1 | Access must be repeated |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write request |
| mem_req_addr | output | 20 | Memory word address |
| mem_req_wdata | output | 16 | Memory write data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_data | input | 16 | Read response word |

## Verification
On every cycle, the assertions check the following:
- a pending request holds steady under back-pressure;
- a retried idle data-port read or an accepted data write is followed by the matching request;
- an address-register or data-port write drops the held word;
- a gated access or a flash-targeted access launches nothing.

Only the bench scenarios can show the rest:
- the end-to-end data path, meaning the memory contents written through the port and read back at the right concatenated address;
- the alternating retry/data rhythm of repeated reads;
- the behaviour across random changes of operating mode and memory latency.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  typedef enum logic [1:0] {
    REG_ADDR_HI = 2'd0,
    REG_ADDR_LO = 2'd1,
    REG_DATA    = 2'd2,
    REG_RSVD    = 2'd3
  } sdp_reg_e;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_RD_REQ  = 2'd1,
    SQ_RD_WAIT = 2'd2,
    SQ_WR_REQ  = 2'd3
  } sdp_state_e;
endpackage

// File: rtl/sdp_mode_gate.sv
module sdp_mode_gate (
  input  logic stopped,
  input  logic suspended,
  input  logic fast_susp,
  output logic open_win
);
  // window open when halted, or in a plain (non-fast) suspend
  assign open_win = stopped | (suspended & ~fast_susp);
endmodule

// File: rtl/sdp_addr_regs.sv
module sdp_addr_regs #(
  parameter int HI_W    = 4,
  parameter int LO_W    = 16,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  output logic              tgt_flash,
  output logic [HI_W+LO_W-1:0] word_addr,
  output logic [DATA_W-1:0] hi_view,
  output logic [DATA_W-1:0] lo_view
);
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      sel_q <= 1'b0;
    end else begin
      if (wr_hi) begin
        hi_q  <= wdata[HI_W-1:0];
        sel_q <= wdata[SEL_BIT];
      end
      if (wr_lo) lo_q <= wdata[LO_W-1:0];
    end
  end

  assign tgt_flash = sel_q;
  assign word_addr = {hi_q, lo_q};

  always_comb begin
    hi_view = '0;
    hi_view[HI_W-1:0] = hi_q;
    hi_view[SEL_BIT]  = sel_q;
    lo_view = '0;
    lo_view[LO_W-1:0] = lo_q;
  end

  AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (word_addr[HI_W+LO_W-1:LO_W] == $past(wdata[HI_W-1:0])) && (tgt_flash == $past(wdata[SEL_BIT]))); // R1
endmodule

// File: rtl/sdp_seq.sv
module sdp_seq
  import sdp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              consume,
  input  logic              invalidate,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_word,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  sdp_state_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= SQ_IDLE;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      rd_valid      <= 1'b0;
      rd_word       <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          if (invalidate || consume) rd_valid <= 1'b0;
          if (start_rd) begin
            st           <= SQ_RD_REQ;
            mem_req_addr <= addr;
          end else if (start_wr) begin
            st            <= SQ_WR_REQ;
            mem_req_addr  <= addr;
            mem_req_wdata <= wdata;
          end
        end
        SQ_RD_REQ:  if (mem_req_ready) st <= SQ_RD_WAIT;
        SQ_RD_WAIT: if (mem_rsp_valid) begin
          st       <= SQ_IDLE;
          rd_valid <= 1'b1;
          rd_word  <= mem_rsp_data;
        end
        SQ_WR_REQ:  if (mem_req_ready) st <= SQ_IDLE;
        default:    st <= SQ_IDLE;
      endcase
    end
  end

  assign busy          = (st != SQ_IDLE);
  assign mem_req_valid = (st == SQ_RD_REQ) || (st == SQ_WR_REQ);
  assign mem_req_write = (st == SQ_WR_REQ);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata))); // R10
  AST_FETCH_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd |=> (mem_req_valid && !mem_req_write && mem_req_addr == $past(addr))); // R3
  AST_WRITE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !start_rd) |=> (mem_req_valid && mem_req_write && mem_req_wdata == $past(wdata))); // R5
  AST_DROP_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (invalidate && !busy) |=> !rd_valid); // R9
endmodule

// File: rtl/sram_diag_port.sv
module sram_diag_port
  import sdp_pkg::*;
#(
  parameter int HI_W    = 4,
  parameter int LO_W    = 16,
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 15,
  localparam int ADDR_W = HI_W + LO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_stopped,
  input  logic              ctl_suspended,
  input  logic              ctl_fast_susp,
  input  logic              hst_sel,
  input  logic              hst_wr,
  input  logic [1:0]        hst_reg,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_retry,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  logic              open_win, busy, rd_valid, tgt_flash;
  logic [DATA_W-1:0] rd_word, hi_view, lo_view;
  logic [ADDR_W-1:0] word_addr;
  logic              acc, free, hit_data, wr_hi, wr_lo;
  logic              start_rd, start_wr, consume, invalidate;
  sdp_reg_e          rsel;

  sdp_mode_gate u_gate (
    .stopped   (ctl_stopped),
    .suspended (ctl_suspended),
    .fast_susp (ctl_fast_susp),
    .open_win  (open_win)
  );

  assign rsel       = sdp_reg_e'(hst_reg);
  assign acc        = hst_sel & open_win;
  assign free       = acc & ~busy;
  assign hit_data   = free & (rsel == REG_DATA) & ~tgt_flash;
  assign wr_hi      = free & hst_wr & (rsel == REG_ADDR_HI);
  assign wr_lo      = free & hst_wr & (rsel == REG_ADDR_LO);
  assign start_wr   = hit_data & hst_wr;
  assign start_rd   = hit_data & ~hst_wr & ~rd_valid;
  assign consume    = hit_data & ~hst_wr & rd_valid;
  assign invalidate = wr_hi | wr_lo | start_wr;

  sdp_addr_regs #(.HI_W(HI_W), .LO_W(LO_W), .DATA_W(DATA_W), .SEL_BIT(SEL_BIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_hi     (wr_hi),
    .wr_lo     (wr_lo),
    .wdata     (hst_wdata),
    .tgt_flash (tgt_flash),
    .word_addr (word_addr),
    .hi_view   (hi_view),
    .lo_view   (lo_view)
  );

  sdp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_rd      (start_rd),
    .start_wr      (start_wr),
    .consume       (consume),
    .invalidate    (invalidate),
    .addr          (word_addr),
    .wdata         (hst_wdata),
    .busy          (busy),
    .rd_valid      (rd_valid),
    .rd_word       (rd_word),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
  );

  assign hst_retry = acc & (busy | start_rd);

  always_comb begin
    hst_rdata = '0;
    if (free && !hst_wr) begin
      unique case (rsel)
        REG_ADDR_HI: hst_rdata = hi_view;
        REG_ADDR_LO: hst_rdata = lo_view;
        REG_DATA:    if (consume) hst_rdata = rd_word;
        default:     hst_rdata = '0;
      endcase
    end
  end

  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && !open_win && !busy) |=> !mem_req_valid); // R7
  AST_FLASH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && tgt_flash && !busy) |=> !mem_req_valid); // R8
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_sel && busy) |=> $stable(word_addr) && $stable(tgt_flash)); // R6
endmodule

// File: tb/sram_diag_port_tb.sv
module sram_diag_port_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctl_stopped = 1'b1, ctl_suspended = 1'b0, ctl_fast_susp = 1'b0;
  logic        hst_sel = 1'b0, hst_wr = 1'b0;
  logic [1:0]  hst_reg = 2'd0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic        hst_retry;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [19:0] mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;

  int errors = 0, checks = 0;
  bit done = 0;
  bit ready_hold = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_diag_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_stopped(ctl_stopped), .ctl_suspended(ctl_suspended), .ctl_fast_susp(ctl_fast_susp),
    .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_reg(hst_reg), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .hst_retry(hst_retry),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // reference model state and memory responder
  logic [15:0] sram    [logic [19:0]];
  logic [15:0] ref_mem [logic [19:0]];
  logic        exp_busy, exp_valid, exp_sel;
  logic [3:0]  exp_hi;
  logic [15:0] exp_lo, exp_word;
  logic [2:0]  lat_cnt;
  logic [19:0] pend_addr, last_addr;
  logic [15:0] last_wdata;
  logic        last_wr;

  function automatic bit win_open(logic s, logic p, logic f);
    return s | (p & ~f);
  endfunction

  function automatic logic [15:0] ref_rd(logic [19:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0;
  endfunction

  function automatic logic [15:0] sram_rd(logic [19:0] a);
    return sram.exists(a) ? sram[a] : 16'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_busy <= 0; exp_valid <= 0; exp_sel <= 0; exp_hi <= 0; exp_lo <= 0; exp_word <= 0;
      lat_cnt <= 0; mem_rsp_valid <= 0; mem_rsp_data <= 0; mem_req_ready <= 0;
      pend_addr <= 0; last_addr <= 0; last_wdata <= 0; last_wr <= 0;
    end else begin
      mem_req_ready <= ready_hold ? 1'b0 : (($urandom % 4) != 0);
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        last_addr <= mem_req_addr; last_wr <= mem_req_write; last_wdata <= mem_req_wdata;
        if (mem_req_write) begin
          sram[mem_req_addr] = mem_req_wdata;
          exp_busy <= 1'b0;
        end else begin
          lat_cnt   <= 3'(1 + ($urandom % 3));
          pend_addr <= mem_req_addr;
        end
      end
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 3'd1;
        if (lat_cnt == 3'd1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= sram_rd(pend_addr);
        end
      end
      if (mem_rsp_valid) begin
        exp_valid <= 1'b1;
        exp_word  <= ref_rd({exp_hi, exp_lo});
        exp_busy  <= 1'b0;
      end
      if (hst_sel && win_open(ctl_stopped, ctl_suspended, ctl_fast_susp) && !exp_busy) begin
        case (hst_reg)
          2'd0: if (hst_wr) begin exp_sel <= hst_wdata[15]; exp_hi <= hst_wdata[3:0]; exp_valid <= 0; end
          2'd1: if (hst_wr) begin exp_lo <= hst_wdata; exp_valid <= 0; end
          2'd2: if (!exp_sel) begin
            if (hst_wr) begin
              ref_mem[{exp_hi, exp_lo}] = hst_wdata;
              exp_busy <= 1; exp_valid <= 0;
            end else if (exp_valid) exp_valid <= 0;
            else exp_busy <= 1;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected host answer computed from the requirements
  task automatic expect_rsp(input bit wr, input logic [1:0] rg, output logic er,
                            output logic [15:0] ed, output string tag);
    er = 0; ed = 0; tag = "R1";
    if (!win_open(ctl_stopped, ctl_suspended, ctl_fast_susp)) tag = "R7";
    else if (exp_busy) begin er = 1; tag = "R6"; end
    else case (rg)
      2'd0: ed = {exp_sel, 11'd0, exp_hi};
      2'd1: ed = exp_lo;
      2'd2: if (exp_sel) tag = "R8";
            else if (wr) tag = "R5";
            else if (exp_valid) begin ed = exp_word; tag = "R4"; end
            else begin er = 1; tag = "R3"; end
      default: ed = 0;
    endcase
  endtask

  task automatic host(input bit wr, input logic [1:0] rg, input logic [15:0] d,
                      output logic got_retry, output logic [15:0] got_data);
    logic er; logic [15:0] ed; string tag;
    @(negedge clk);
    chk(!(mem_req_valid && !exp_busy), "R10", 32'(mem_req_valid), 32'(exp_busy));
    hst_sel = 1; hst_wr = wr; hst_reg = rg; hst_wdata = d;
    #1;
    expect_rsp(wr, rg, er, ed, tag);
    got_retry = hst_retry; got_data = hst_rdata;
    chk(hst_retry == er, tag, 32'(hst_retry), 32'(er));
    if (!wr) chk(hst_rdata == ed, tag, 32'(hst_rdata), 32'(ed));
    @(posedge clk); #1;
    hst_sel = 0;
  endtask

  task automatic set_mode(input logic s, input logic p, input logic f);
    @(negedge clk);
    ctl_stopped = s; ctl_suspended = p; ctl_fast_susp = f;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && exp_busy; i++) @(negedge clk);
  endtask

  task automatic poll_read(output logic [15:0] d);
    logic r;
    d = 0;
    for (int i = 0; i < 30; i++) begin
      host(0, 2'd2, 16'h0, r, d);
      if (!r) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic r; logic [15:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk(!mem_req_valid, "R1", 32'(mem_req_valid), 0);
    host(0, 2'd0, 0, r, d);
    host(0, 2'd3, 0, r, d);

    // R1 R2 address load and readback
    host(1, 2'd0, 16'h7FF5, r, d);
    host(1, 2'd1, 16'h0003, r, d);
    host(0, 2'd0, 0, r, d);
    chk(d == 16'h0005, "R1", 32'(d), 32'h5);
    host(0, 2'd1, 0, r, d);
    host(1, 2'd3, 16'hFFFF, r, d);
    host(0, 2'd3, 0, r, d);

    // R3 first read retries, R6 busy retries
    host(0, 2'd2, 0, r, d);
    chk(r == 1, "R3", 32'(r), 1);
    host(0, 2'd0, 0, r, d);
    chk(r == 1, "R6", 32'(r), 1);
    wait_idle();
    chk(last_addr == 20'h50003 && !last_wr, "R2", 32'(last_addr), 32'h50003);
    poll_read(d);
    chk(d == 16'h0, "R4", 32'(d), 0);

    // R5 R10 write held under back-pressure
    ready_hold = 1;
    host(1, 2'd2, 16'hBEEF, r, d);
    chk(r == 0, "R5", 32'(r), 0);
    repeat (3) @(negedge clk);
    chk(mem_req_valid && mem_req_write && mem_req_addr == 20'h50003 && mem_req_wdata == 16'hBEEF,
        "R10", 32'(mem_req_wdata), 32'hBEEF);
    ready_hold = 0;
    wait_idle();
    chk(last_wr && last_wdata == 16'hBEEF, "R5", 32'(last_wdata), 32'hBEEF);
    poll_read(d);
    chk(d == 16'hBEEF, "R4", 32'(d), 32'hBEEF);
    host(0, 2'd2, 0, r, d);
    chk(r == 1, "R4", 32'(r), 1);
    wait_idle();

    // R9 address write discards held word
    host(1, 2'd1, 16'h0003, r, d);
    host(0, 2'd2, 0, r, d);
    chk(r == 1, "R9", 32'(r), 1);
    wait_idle();

    // R7 gated modes
    set_mode(0, 0, 0);
    host(0, 2'd2, 0, r, d);
    host(1, 2'd1, 16'h1234, r, d);
    set_mode(0, 1, 1);
    host(1, 2'd2, 16'h5555, r, d);
    @(negedge clk);
    chk(!mem_req_valid, "R7", 32'(mem_req_valid), 0);
    set_mode(0, 1, 0);
    host(0, 2'd1, 0, r, d);
    chk(d == 16'h0003, "R7", 32'(d), 3);

    // R8 flash target ignored
    host(1, 2'd0, 16'h8002, r, d);
    host(0, 2'd2, 0, r, d);
    host(1, 2'd2, 16'h1111, r, d);
    @(negedge clk);
    chk(!mem_req_valid, "R8", 32'(mem_req_valid), 0);
    host(1, 2'd0, 16'h0002, r, d);

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] rg; logic [15:0] wd; bit wr;
      if (($urandom % 10) == 0) begin
        case ($urandom % 5)
          0: set_mode(0, 0, 0);
          1: set_mode(0, 1, 1);
          2: set_mode(0, 1, 0);
          default: set_mode(1, $urandom % 2, $urandom % 2);
        endcase
      end
      rg = 2'($urandom % 4);
      wr = ($urandom % 3) == 0;
      wd = 16'($urandom);
      if (rg == 2'd0) wd = {(($urandom % 7) == 0), 11'd0, 4'($urandom % 4)};
      if (rg == 2'd1) wd = 16'($urandom % 8);
      host(wr, rg, wd, r, d);
      if (($urandom % 4) == 0) @(negedge clk);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule